// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block sits in the read path of a parallel flash device. It follows one internal program or erase operation at a time and records whether it is running, has finished or has failed. While the device is in status mode, a read returns a status word instead of array contents. Bit 7 is a completion indicator, bit 6 changes on every read while the operation is still unresolved, and bit 5 is an error flag. In read mode, a read returns the array data word without change.

A small configuration register picks one of two status styles. In the default style, bit 7 shows the inverse of bit 7 of the data being programmed, or 0 during an erase, and the device returns to read mode on its own after a successful operation. In the alternate style, bit 7 is a plain busy-low/done-high flag and the device stays in status mode until an exit command arrives. A failed operation always waits for the exit command. A failure is either the pulse limit being exceeded or a start aimed at a protected sector. The array, the command byte sequences and the pulse timing are outside the block and arrive as single-cycle strobes.

Top module: `flash_status_reporter`

## Requirements
- R1: After rst_n is low at a clock edge, status_mode is 0 and rd_data is 0. The style register holds 0 at power-up, and rst_n does not change it.
- R2: A cfg_wr with cfg_val 2'b00 (auto-return style) or 2'b01 (hold style) is accepted only in read mode. A cfg_wr with any other value, or a cfg_wr while in status mode, leaves the style unchanged.
- R3: In auto-return style, a status read returns the inverse of bit 7 of the latched load_data on bit 7 while a program is busy. It returns 0 on bit 7 while an erase is busy.
- R4: In hold style, bit 7 reads 0 while the operation is busy and 1 once it has ended, whether it succeeded or failed.
- R5: Bit 6 is cleared when an operation is accepted. While the operation is busy or held after a failure, each status read returns bit 6 and then inverts it. After a success in hold style, bit 6 no longer changes.
- R6: Bit 5 reads 0 while busy and after a success. It reads 1 after op_fail, and after an accepted start with sect_prot high. A start with sect_prot high goes straight to the failed hold.
- R7: In status mode, every rd_data bit other than 7, 6 and 5 reads 0.
- R8: op_done ends a busy operation. In auto-return style the device goes back to read mode. In hold style it stays in status mode until exit_cmd.
- R9: After a failure, status mode persists in either style until exit_cmd. exit_cmd has no effect in read mode or while busy.
- R10: A read in read mode returns array_data unchanged, one cycle after rd_stb.
- R11: op_start is ignored unless the device is in read mode.
- R12: When op_done and op_fail arrive in the same cycle, the failure wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Read access strobe, one cycle per read |
| array_data | input | DW | Word from the array for the current read |
| op_start | input | 1 | Program or erase request |
| op_erase | input | 1 | With op_start: 1 for erase, 0 for program |
| sect_prot | input | 1 | With op_start: target sector is protected |
| load_data | input | DW | With op_start: last loaded data word |
| op_done | input | 1 | Internal operation finished and verified |
| op_fail | input | 1 | Internal pulse-count limit exceeded |
| cfg_wr | input | 1 | Style configuration write |
| cfg_val | input | 2 | Value for the style register |
| exit_cmd | input | 1 | Return-to-read-mode command |
| rd_data | output | DW | Read data, registered on rd_stb |
| status_mode | output | 1 | 1 while reads return status |

## Verification
The hardest point to reach is the bit 6 history inside a failed hold. To check it, the bench has to count every read since the operation was accepted. It also has to show that a start attempted during the hold neither clears the toggle nor replaces the latched data. The bench counts the reads itself. It alternates between busy reads, a failure and further reads, and places a rejected op_start and a rejected cfg_wr inside the hold before it gives exit_cmd. The persistence of the style register across rst_n is visible only through bit 7 of a later operation. The bench therefore sets hold style, resets, and starts a program whose data makes the two styles give opposite bit 7 values.

// File: rtl/fsr_pkg.sv
// Package: shared state encoding and status bit positions for the
// flash status reporter. Assumes a data word of at least 8 bits.
package fsr_pkg;
    typedef enum logic [1:0] {
        ST_READ    = 2'd0,   // array reads
        ST_BUSY    = 2'd1,   // operation running
        ST_HOLD_OK = 2'd2,   // success, hold style, wait for exit
        ST_HOLD_ER = 2'd3    // failure, wait for exit
    } fsr_state_e;

    localparam int BIT_DONE = 7;
    localparam int BIT_TOG  = 6;
    localparam int BIT_ERR  = 5;
endpackage

// File: rtl/fsr_ctrl.sv
// Operation sequencer: owns the mode state, the style register and the
// values latched at start. Assumes the event strobes last one cycle.
// The style register is initialised at power-up and is not touched by rst_n.
module fsr_ctrl
    import fsr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start,
    input  logic       op_erase,
    input  logic       sect_prot,
    input  logic [DW-1:0] load_data,
    input  logic       op_done,
    input  logic       op_fail,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_val,
    input  logic       exit_cmd,
    output fsr_state_e state,
    output logic       hold_style,
    output logic       erase_q,
    output logic       d7_q,
    output logic       start_acc
);
    fsr_state_e state_q, state_d;
    logic       style_q = 1'b0;
    logic       unused_load;

    assign unused_load = ^{load_data[DW-1:8], load_data[6:0]};
    assign start_acc   = op_start && (state_q == ST_READ);

    // next-state selection; a failure outranks a success
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READ:    if (op_start) state_d = sect_prot ? ST_HOLD_ER : ST_BUSY;
            ST_BUSY:    if (op_fail) state_d = ST_HOLD_ER;
                        else if (op_done) state_d = style_q ? ST_HOLD_OK : ST_READ;
            ST_HOLD_OK: if (exit_cmd) state_d = ST_READ;
            ST_HOLD_ER: if (exit_cmd) state_d = ST_READ;
            default:    state_d = ST_READ;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_d;
    end

    // style register: legal values only, read mode only, not reset
    always_ff @(posedge clk) begin
        if (cfg_wr && !cfg_val[1] && state_q == ST_READ)
            style_q <= cfg_val[0];
    end

    // operation attributes captured on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_q <= 1'b0;
            d7_q    <= 1'b0;
        end else if (start_acc) begin
            erase_q <= op_erase;
            d7_q    <= load_data[7];
        end
    end

    assign state      = state_q;
    assign hold_style = style_q;

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_ER && !exit_cmd) |=> state_q == ST_HOLD_ER);
    // R11
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !op_done && !op_fail) |=> state_q == ST_BUSY);
    // R8
    auto_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && op_done && !op_fail && !style_q) |=> state_q == ST_READ);
    // R2
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READ) |=> $stable(style_q));
    // R12
    fail_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && op_fail) |=> state_q == ST_HOLD_ER);
endmodule

// File: rtl/fsr_toggle.sv
// Bit 6 source: a flip-flop cleared on an accepted start and inverted on
// each counted status read. Assumes clr and adv are never high together.
module fsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic tog
);
    logic tog_q;

    // toggle flip-flop
    always_ff @(posedge clk) begin
        if (!rst_n)   tog_q <= 1'b0;
        else if (clr) tog_q <= 1'b0;
        else if (adv) tog_q <= ~tog_q;
    end

    assign tog = tog_q;

    // R5
    tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tog_q);
    // R5
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(tog_q));
endmodule

// File: rtl/fsr_rdmux.sv
// Read register: on each read strobe, captures either the array word or
// the status word built from the current state. Assumes DW >= 8.
module fsr_rdmux
    import fsr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  fsr_state_e    state,
    input  logic          hold_style,
    input  logic          erase_q,
    input  logic          d7_q,
    input  logic          tog,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data
);
    localparam logic [DW-1:0] STAT_MASK = (DW'(1) << BIT_DONE) |
                                          (DW'(1) << BIT_TOG)  |
                                          (DW'(1) << BIT_ERR);
    logic [DW-1:0] stat_w;
    logic          b7;
    logic          in_status;

    assign in_status = (state != ST_READ);

    // bit 7 per style and phase
    always_comb begin
        if (state == ST_HOLD_OK)   b7 = 1'b1;
        else if (hold_style)       b7 = (state == ST_HOLD_ER);
        else                       b7 = erase_q ? 1'b0 : ~d7_q;
    end

    // status word assembly
    always_comb begin
        stat_w           = '0;
        stat_w[BIT_DONE] = b7;
        stat_w[BIT_TOG]  = tog;
        stat_w[BIT_ERR]  = (state == ST_HOLD_ER);
    end

    // read data register
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= in_status ? stat_w : array_data;
    end

    // R7
    status_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && in_status) |=> (rd_data & ~STAT_MASK) == '0);
    // R10
    array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !in_status) |=> rd_data == $past(array_data));
    // R6
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && state == ST_HOLD_ER) |=> rd_data[BIT_ERR]);
endmodule

// File: rtl/flash_status_reporter.sv
// Top: status read path of a parallel flash device. Connects the
// sequencer, the bit 6 toggle and the read register. Assumes single-cycle
// strobes and a synchronous active-low reset.
module flash_status_reporter
    import fsr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic [DW-1:0] array_data,
    input  logic          op_start,
    input  logic          op_erase,
    input  logic          sect_prot,
    input  logic [DW-1:0] load_data,
    input  logic          op_done,
    input  logic          op_fail,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_val,
    input  logic          exit_cmd,
    output logic [DW-1:0] rd_data,
    output logic          status_mode
);
    fsr_state_e state;
    logic       hold_style, erase_q, d7_q, start_acc, tog, tog_adv;

    fsr_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
        .sect_prot(sect_prot), .load_data(load_data), .op_done(op_done),
        .op_fail(op_fail), .cfg_wr(cfg_wr), .cfg_val(cfg_val),
        .exit_cmd(exit_cmd), .state(state), .hold_style(hold_style),
        .erase_q(erase_q), .d7_q(d7_q), .start_acc(start_acc)
    );

    // reads advance bit 6 only while the outcome is busy or failed
    assign tog_adv = rd_stb && (state == ST_BUSY || state == ST_HOLD_ER);

    fsr_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .clr(start_acc), .adv(tog_adv), .tog(tog)
    );

    fsr_rdmux #(.DW(DW)) u_mux (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .state(state),
        .hold_style(hold_style), .erase_q(erase_q), .d7_q(d7_q), .tog(tog),
        .array_data(array_data), .rd_data(rd_data)
    );

    assign status_mode = (state != ST_READ);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!status_mode && rd_data == '0));
endmodule

// File: tb/flash_status_reporter_test.sv
module flash_status_reporter_test;
    localparam int DW = 16;

    logic clk = 0, rst_n = 0, rd_stb = 0, op_start = 0, op_erase = 0;
    logic sect_prot = 0, op_done = 0, op_fail = 0, cfg_wr = 0, exit_cmd = 0;
    logic [1:0]    cfg_val = 0;
    logic [DW-1:0] array_data = 16'h1234, load_data = 0, rd_data;
    logic          status_mode;
    int checks = 0, failures = 0;
    bit finished = 0;
    logic tog_m;

    flash_status_reporter #(.DW(DW)) uut (.*);

    always #2 clk = ~clk;

    // vector: {cfg[1:0], erase, prot, fail, data7}
    localparam logic [5:0] VEC [8] = '{
        6'b00_0_0_0_1, 6'b00_0_0_0_0, 6'b00_1_0_0_1, 6'b00_0_0_1_1,
        6'b01_0_0_0_1, 6'b01_1_0_0_0, 6'b01_0_0_1_0, 6'b00_0_1_0_0 };

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start(logic er, logic pr, logic [DW-1:0] d);
        @(negedge clk); op_start = 1; op_erase = er; sect_prot = pr; load_data = d;
        @(negedge clk); op_start = 0; op_erase = 0; sect_prot = 0;
    endtask

    task automatic set_cfg(logic [1:0] v);
        @(negedge clk); cfg_wr = 1; cfg_val = v;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic do_exit();
        @(negedge clk); exit_cmd = 1;
        @(negedge clk); exit_cmd = 0;
    endtask

    task automatic do_read(output logic [DW-1:0] v);
        @(negedge clk); rd_stb = 1;
        @(negedge clk); rd_stb = 0; v = rd_data;
    endtask

    // phase: 0 busy, 1 failed hold, 2 success hold
    function automatic logic [DW-1:0] exp_stat(logic sty, logic er, logic d7, logic t, int ph);
        logic [DW-1:0] w = '0;
        if (ph == 2)  w[7] = 1;
        else if (sty) w[7] = (ph == 1);
        else          w[7] = er ? 1'b0 : ~d7;
        w[6] = t;
        w[5] = (ph == 1);
        return w;
    endfunction

    task automatic stat_read(string req, logic sty, logic er, logic d7, int ph);
        logic [DW-1:0] v;
        do_read(v);
        chk(req, v, exp_stat(sty, er, d7, tog_m, ph));
        if (ph != 2) tog_m = ~tog_m;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status_mode", {15'b0, status_mode}, 16'h0);
        chk("R1 rd_data", rd_data, 16'h0);
        rst_n = 1;
        // R10 plain read with power-up style 00
        array_data = 16'hBEEF; do_read(v); chk("R10 array read", v, 16'hBEEF);

        // table walk: R3 R4 R5 R6 R7 R8 R9
        foreach (VEC[i]) begin
            logic sty, er, pr, fl, d7;
            sty = VEC[i][4]; er = VEC[i][3]; pr = VEC[i][2]; fl = VEC[i][1]; d7 = VEC[i][0];
            set_cfg(VEC[i][5:4]);
            pulse_start(er, pr, {8'hA5, d7, 7'h3C});
            tog_m = 0;
            chk("R6 enter status", {15'b0, status_mode}, 16'h1);
            if (pr) begin
                stat_read("R6 protected", sty, er, d7, 1);
                stat_read("R5 protected toggle", sty, er, d7, 1);
                do_exit();
            end else begin
                stat_read(sty ? "R4 busy" : "R3 busy", sty, er, d7, 0);
                stat_read("R5 busy toggle", sty, er, d7, 0);
                stat_read("R7 busy word", sty, er, d7, 0);
                @(negedge clk); if (fl) op_fail = 1; else op_done = 1;
                @(negedge clk); op_fail = 0; op_done = 0;
                if (fl) begin
                    stat_read("R6 fail flag", sty, er, d7, 1);
                    stat_read("R9 fail hold", sty, er, d7, 1);
                    do_exit();
                end else if (sty) begin
                    stat_read("R8 hold style", sty, er, d7, 2);
                    stat_read("R5 frozen", sty, er, d7, 2);
                    do_exit();
                end
            end
            chk("R8 back to read", {15'b0, status_mode}, 16'h0);
            array_data = 16'h0F00 + 16'(i); do_read(v);
            chk("R10 read after op", v, 16'h0F00 + 16'(i));
        end

        // R2 illegal value ignored (style stays 01); R1 style survives reset
        set_cfg(2'b01); set_cfg(2'b10);
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        chk("R1 reset again", {15'b0, status_mode}, 16'h0);
        pulse_start(0, 0, 16'h0000); tog_m = 0;
        stat_read("R1 R2 style kept", 1, 0, 0, 0);
        // R9 exit while busy ignored
        do_exit(); chk("R9 exit in busy", {15'b0, status_mode}, 16'h1);
        // R12 done and fail together
        @(negedge clk); op_done = 1; op_fail = 1;
        @(negedge clk); op_done = 0; op_fail = 0;
        stat_read("R12 fail wins", 1, 0, 0, 1);
        // R11 start in hold ignored (no toggle clear, no new data); R2 cfg write in hold ignored
        pulse_start(1, 0, 16'hFFFF);
        set_cfg(2'b00);
        stat_read("R11 start ignored", 1, 0, 0, 1);
        do_exit();
        pulse_start(0, 0, 16'h0000); tog_m = 0;
        stat_read("R2 cfg in hold ignored", 1, 0, 0, 0);
        @(negedge clk); op_done = 1; @(negedge clk); op_done = 0;
        do_exit();
        // R9 exit in read mode: no change
        do_exit(); chk("R9 exit in read", {15'b0, status_mode}, 16'h0);
        array_data = 16'h5A5A; do_read(v); chk("R10 final read", v, 16'h5A5A);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule